// File: doc/BRIEF.md
# External Interrupt Pin Detector and Priority Arbiter

This block watches a bank of external interrupt pins and tells the CPU which one to serve next. Every pin first crosses a two-stage synchronizer. It is then tested against its own detection type: rising edge, falling edge, low level or high level. A detected request is stored in a per-pin pending latch. A registered arbiter takes the unmasked pending requests and presents the best one as a priority level and a pin index. A level of 0 means nothing is waiting.

Edge requests and level requests are released differently. An edge request stays set until the CPU acknowledges that same pin. A level request is latched when it is seen and is held after the pin goes inactive again. It is released when the CPU acknowledges any source, or when the mask bit of that pin is set. If its pin is still active at that point, the request is latched again.

The pins act as independent requests only while the independent-pin enable is high. Each pin is also dropped from consideration while its mask bit is set or its priority field is zero.

Top module: `ext_irq_arb`

## Requirements
- R1: Pins pass through two synchronizer flops before detection. Reset clears the synchronizer, the edge history and every pending latch. A pin change applied just after a clock edge first shows on reqLevel after the fourth following rising edge. After reset, reqLevel and reqIdx are 0.
- R2: Each pin has a 2-bit detection field, at bits [2i+1:2i] of detMode: 00 is low level, 01 is falling edge, 10 is rising edge and 11 is high level.
- R3: In an edge mode (01 or 10), a detected edge sets a pending flag. The flag is cleared only by an acknowledge that carries the same pin index. An acknowledge of another pin leaves it set.
- R4: In a level mode (00 or 11), a request seen at the active level is latched. It stays pending after the pin returns to its inactive level.
- R5: A latched level request is cleared by an acknowledge of any pin index, whether its own or another. If the pin is still at its active level, the request latches again.
- R6: While maskBit[i] is 1, pin i's pending latch is cleared and no new request is detected on it. A held level request whose pin has gone inactive stays cleared after the mask is removed.
- R7: A pin whose 4-bit priority field prioLvl[4i+3:4i] is 0 is ignored. It never wins, and its pending latch is cleared.
- R8: While indepEn is 0, no pin is detected and all pending latches are cleared. An edge that occurs while the block is disabled is not remembered.
- R9: reqLevel carries the highest priority among the pending, enabled pins, and reqIdx carries its index. Equal priorities go to the higher pin index. Both outputs are registered one cycle after the pending latches.
- R10: When nothing is pending, reqLevel is 0 and reqIdx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NUM_SRC | Raw external interrupt pins |
| detMode | input | 2*NUM_SRC | Per-pin detection type, 2 bits per pin |
| prioLvl | input | PRIO_W*NUM_SRC | Per-pin priority, 0 disables the pin |
| indepEn | input | 1 | Enables the pins as independent requests |
| maskBit | input | NUM_SRC | Per-pin mask; 1 clears and blocks the pin |
| ackValid | input | 1 | CPU accepts an interrupt this cycle |
| ackIdx | input | IDX_W | Index of the accepted pin |
| reqLevel | output | PRIO_W | Priority of the winning request, 0 if none |
| reqIdx | output | IDX_W | Pin index of the winning request |

## Verification
The bench builds the block with its defaults: eight pins and 4-bit priorities. This makes all sixteen priority values, including the masking value 0, and every tie between pin indices reachable. Randomized rounds give each pin a random detection type and priority, raise random groups of pins and then drain the queue by acknowledging each winner in turn. The drain shows how level requests release on foreign acknowledges while edge requests survive them. Directed cases pin down the four-edge latency, the sticky level hold, mask release and the disabled-mode behaviour.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int IRQ_COUNT = 8;
  localparam int PRIO_BITS = 4;

  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_FALL = 2'b01,
    DET_RISE = 2'b10,
    DET_HIGH = 2'b11
  } det_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [IRQ_COUNT-1:0] setVec;   // new detection this cycle
    logic [IRQ_COUNT-1:0] dropVec;  // release pending latch
    logic [IRQ_COUNT-1:0] liveVec;  // pin currently eligible
  } irq_strobe_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        candVec,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  output logic [PRIO_W-1:0]         bestLvl,
  output logic [IDX_W-1:0]          bestIdx
);
  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (candVec[i] && (prioFlat[i*PRIO_W +: PRIO_W] != '0) &&
          (prioFlat[i*PRIO_W +: PRIO_W] >= bestLvl)) begin
        bestLvl = prioFlat[i*PRIO_W +: PRIO_W];
        bestIdx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_detect_ctl.sv
module irq_detect_ctl
  import ext_irq_pkg::*;
#(
  parameter int NUM_SRC = IRQ_COUNT,
  parameter int PRIO_W  = PRIO_BITS,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        syncLvl,
  input  logic [NUM_SRC-1:0]        prevLvl,
  input  logic [2*NUM_SRC-1:0]      modeFlat,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  input  logic                      indepEn,
  input  logic [NUM_SRC-1:0]        maskBit,
  input  logic                      ackValid,
  input  logic [IDX_W-1:0]          ackIdx,
  output irq_strobe_t               strobe
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pin
    det_mode_e pinMode;
    logic      live, isLevel, hit, ackSelf, ackOther;

    assign pinMode  = det_mode_e'(modeFlat[2*i +: 2]);
    assign live     = indepEn && !maskBit[i] && (prioFlat[i*PRIO_W +: PRIO_W] != '0);
    assign isLevel  = (pinMode == DET_LOW) || (pinMode == DET_HIGH);
    assign ackSelf  = ackValid && (ackIdx == IDX_W'(i));
    assign ackOther = ackValid && (ackIdx != IDX_W'(i));

    always_comb begin
      case (pinMode)
        DET_LOW:  hit = !syncLvl[i];
        DET_HIGH: hit = syncLvl[i];
        DET_RISE: hit = syncLvl[i] && !prevLvl[i];
        DET_FALL: hit = !syncLvl[i] && prevLvl[i];
        default:  hit = 1'b0;
      endcase
    end

    assign strobe.liveVec[i] = live;
    assign strobe.setVec[i]  = live && hit;
    assign strobe.dropVec[i] = !live || ackSelf || (isLevel && ackOther);
  end
endmodule

// File: rtl/irq_detect_dp.sv
module irq_detect_dp
  import ext_irq_pkg::*;
#(
  parameter int NUM_SRC = IRQ_COUNT,
  parameter int PRIO_W  = PRIO_BITS,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        pinIn,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  input  irq_strobe_t               strobe,
  output logic [NUM_SRC-1:0]        syncLvl,
  output logic [NUM_SRC-1:0]        prevLvl,
  output logic [NUM_SRC-1:0]        pendVec,
  output logic [PRIO_W-1:0]         reqLevel,
  output logic [IDX_W-1:0]          reqIdx
);
  logic [NUM_SRC-1:0] metaLvl;
  logic [PRIO_W-1:0]  pickLvl;
  logic [IDX_W-1:0]   pickIdx;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        metaLvl[i] <= 1'b0;
        syncLvl[i] <= 1'b0;
        prevLvl[i] <= 1'b0;
        pendVec[i] <= 1'b0;
      end else begin
        metaLvl[i] <= pinIn[i];
        syncLvl[i] <= metaLvl[i];
        prevLvl[i] <= syncLvl[i];
        pendVec[i] <= (pendVec[i] && !strobe.dropVec[i]) || strobe.setVec[i];
      end
    end

    // R1
    pend_from_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pendVec[i]) |-> $past(strobe.setVec[i]));
  end

  irq_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
    .candVec (pendVec & strobe.liveVec),
    .prioFlat(prioFlat),
    .bestLvl (pickLvl),
    .bestIdx (pickIdx)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqLevel <= '0;
      reqIdx   <= '0;
    end else begin
      reqLevel <= pickLvl;
      reqIdx   <= pickIdx;
    end
  end

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pendVec) == '0) |-> (reqLevel == '0 && reqIdx == '0));
endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb
  import ext_irq_pkg::*;
#(
  parameter int NUM_SRC = IRQ_COUNT,
  parameter int PRIO_W  = PRIO_BITS,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        pinIn,
  input  logic [2*NUM_SRC-1:0]      detMode,
  input  logic [NUM_SRC*PRIO_W-1:0] prioLvl,
  input  logic                      indepEn,
  input  logic [NUM_SRC-1:0]        maskBit,
  input  logic                      ackValid,
  input  logic [IDX_W-1:0]          ackIdx,
  output logic [PRIO_W-1:0]         reqLevel,
  output logic [IDX_W-1:0]          reqIdx
);
  irq_strobe_t        strobe;
  logic [NUM_SRC-1:0] syncLvl, prevLvl, pendVec;

  irq_detect_ctl #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_ctl (
    .syncLvl (syncLvl),
    .prevLvl (prevLvl),
    .modeFlat(detMode),
    .prioFlat(prioLvl),
    .indepEn (indepEn),
    .maskBit (maskBit),
    .ackValid(ackValid),
    .ackIdx  (ackIdx),
    .strobe  (strobe)
  );

  irq_detect_dp #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .prioFlat(prioLvl),
    .strobe  (strobe),
    .syncLvl (syncLvl),
    .prevLvl (prevLvl),
    .pendVec (pendVec),
    .reqLevel(reqLevel),
    .reqIdx  (reqIdx)
  );

  // R6
  mask_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec & $past(maskBit)) == '0);

  // R8
  disabled_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(indepEn) |-> (pendVec == '0));

  // R9
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqLevel != '0) |-> ($past(pendVec) != '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hold
    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(pendVec[i]) && $past(!ackValid && indepEn && !maskBit[i] &&
        (prioLvl[i*PRIO_W +: PRIO_W] != '0))) |-> pendVec[i]);
  end
endmodule

// File: tb/ext_irq_arb_bench.sv
`timescale 1ns/1ps
module ext_irq_arb_bench;
  localparam int N = 8;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  pinIn = '0;
  logic [2*N-1:0] detMode = '0;
  logic [N*PW-1:0] prioLvl = '0;
  logic          indepEn = 1'b0;
  logic [N-1:0]  maskBit = '0;
  logic          ackValid = 1'b0;
  logic [2:0]    ackIdx = '0;
  logic [PW-1:0] reqLevel;
  logic [2:0]    reqIdx;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ext_irq_arb u_ext_irq_arb (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .detMode(detMode),
    .prioLvl(prioLvl), .indepEn(indepEn), .maskBit(maskBit),
    .ackValid(ackValid), .ackIdx(ackIdx), .reqLevel(reqLevel), .reqIdx(reqIdx)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_req(input string tag, input int eLvl, input int eIdx);
    checks++;
    if (reqLevel != PW'(eLvl) || reqIdx != 3'(eIdx)) begin
      errors++;
      $display("FAIL %s: got level %0d idx %0d, expected level %0d idx %0d",
               tag, reqLevel, reqIdx, eLvl, eIdx);
    end
  endtask

  task automatic set_pin(input int i, input logic [1:0] m, input int p);
    detMode[2*i +: 2] = m;
    prioLvl[i*PW +: PW] = PW'(p);
  endtask

  task automatic ack(input int i);
    ackValid = 1'b1;
    ackIdx = 3'(i);
    tick(1);
    ackValid = 1'b0;
    tick(6);
  endtask

  function automatic void best(input logic [N-1:0] pv, input logic [N*PW-1:0] pr,
                               output int l, output int x);
    l = 0; x = 0;
    for (int i = 0; i < N; i++) begin
      int p = int'(pr[i*PW +: PW]);
      if (pv[i] && p != 0 && p >= l) begin l = p; x = i; end
    end
  endfunction

  function automatic logic idle_of(input logic [1:0] m);
    return (m == 2'b00 || m == 2'b01);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bl, bx;
    logic [N-1:0] expPend, act, lvlMask;
    void'($urandom(32'd7319));

    for (int i = 0; i < N; i++) set_pin(i, 2'b10, 0);
    tick(3);
    rstN = 1'b1;
    tick(1);
    expect_req("R1 reset state", 0, 0);

    // R1 latency and R2 rising edge
    set_pin(0, 2'b10, 5);
    indepEn = 1'b1;
    tick(2);
    pinIn[0] = 1'b1;
    tick(3);
    expect_req("R1 three edges still idle", 0, 0);
    tick(1);
    expect_req("R1 fourth edge shows request", 5, 0);

    // R9 tie to higher index, R3 foreign ack keeps edge
    set_pin(3, 2'b10, 5);
    pinIn[3] = 1'b1; tick(3); pinIn[3] = 1'b0; tick(6);
    expect_req("R9 tie favours higher index", 5, 3);
    ack(0);
    expect_req("R3 edge survives foreign ack", 5, 3);
    ack(3);
    expect_req("R3 own ack clears edge", 0, 0);

    // R4 high-level sticky
    set_pin(5, 2'b11, 7);
    pinIn[5] = 1'b1; tick(6);
    expect_req("R4 high level detected", 7, 5);
    pinIn[5] = 1'b0; tick(6);
    expect_req("R4 level held after pin drops", 7, 5);

    // R5 foreign ack releases held level
    set_pin(2, 2'b10, 2);
    pinIn[2] = 1'b1; tick(3); pinIn[2] = 1'b0; tick(6);
    expect_req("R5 lower pin does not win", 7, 5);
    ack(2);
    expect_req("R5 foreign ack releases level", 0, 0);

    // R6 mask releases held low level
    set_pin(6, 2'b00, 9);
    pinIn[6] = 1'b0; tick(6);
    expect_req("R2 low level detected", 9, 6);
    pinIn[6] = 1'b1; tick(6);
    expect_req("R4 low level held", 9, 6);
    maskBit[6] = 1'b1; tick(6);
    expect_req("R6 mask clears held level", 0, 0);
    maskBit[6] = 1'b0; tick(6);
    expect_req("R6 unmask keeps cleared", 0, 0);

    // R7 priority zero ignored
    set_pin(1, 2'b11, 0);
    pinIn[1] = 1'b1; tick(6);
    expect_req("R7 zero priority ignored", 0, 0);
    set_pin(1, 2'b11, 3); tick(6);
    expect_req("R7 nonzero priority detects", 3, 1);
    set_pin(1, 2'b11, 0); tick(6);
    expect_req("R7 zero priority clears", 0, 0);
    pinIn[1] = 1'b0;

    // R8 disabled mode
    indepEn = 1'b0;
    set_pin(4, 2'b10, 8);
    pinIn[4] = 1'b1; tick(3); pinIn[4] = 1'b0; tick(6);
    expect_req("R8 disabled ignores edge", 0, 0);
    indepEn = 1'b1; tick(6);
    expect_req("R8 edge not remembered", 0, 0);

    // R2 falling edge
    set_pin(4, 2'b01, 6);
    pinIn[4] = 1'b1; tick(6);
    expect_req("R2 falling mode ignores rise", 0, 0);
    pinIn[4] = 1'b0; tick(6);
    expect_req("R2 falling edge detected", 6, 4);
    ack(4);
    expect_req("R3 falling edge acked", 0, 0);

    // R5 own ack with pin still active re-latches
    set_pin(7, 2'b11, 4);
    pinIn[7] = 1'b1; tick(6);
    expect_req("R4 pin7 high", 4, 7);
    ack(7);
    expect_req("R5 relatch while active", 4, 7);
    pinIn[7] = 1'b0; tick(2);
    ack(7);
    expect_req("R5 own ack clears level", 0, 0);

    // randomized rounds
    for (int r = 0; r < 40; r++) begin
      indepEn = 1'b0; maskBit = '0;
      lvlMask = '0;
      for (int i = 0; i < N; i++) begin
        logic [1:0] m = 2'($urandom());
        set_pin(i, m, int'($urandom() % 16));
        pinIn[i] = idle_of(m);
        lvlMask[i] = (m == 2'b00 || m == 2'b11);
      end
      tick(6);
      indepEn = 1'b1; tick(6);
      expect_req("R10 random round idle", 0, 0);
      act = N'($urandom());
      pinIn = pinIn ^ act;
      tick(6);
      expPend = '0;
      for (int i = 0; i < N; i++)
        expPend[i] = act[i] && (prioLvl[i*PW +: PW] != '0);
      best(expPend, prioLvl, bl, bx);
      expect_req("R9 random arbitration", bl, bx);
      for (int i = 0; i < N; i++) pinIn[i] = idle_of(detMode[2*i +: 2]);
      tick(6);
      expect_req("R4 random hold after idle", bl, bx);
      for (int k = 0; k < N && expPend != '0; k++) begin
        best(expPend, prioLvl, bl, bx);
        ack(bx);
        expPend[bx] = 1'b0;
        expPend = expPend & ~lvlMask;
        best(expPend, prioLvl, bl, bx);
        expect_req("R5 random drain", bl, bx);
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule